// File: doc/BRIEF.md
# Interrupt Controller Register Port

This block is the byte-wide programming port of a single eight-input interrupt controller unit. Software reaches it through a one-bit address and write/read strobes. An initialization word starts a short setup sequence that loads the vector base, skips a cascade word, and optionally takes a mode word. After the sequence, the same port accepts operation commands. These commands read back internal registers, move the rotating priority offset, and retire in-service bits through end-of-interrupt codes.

The unit latches requests from its eight inputs. A separate trigger-mode register, reached through its own select line, chooses edge or level capture for each input. Only the bits enabled by a fixed writable mask can be set. A simple rotating-priority resolver compares the best unmasked request against the best in-service level and drives an interrupt output. A one-cycle service-entry strobe moves the winner into service. A poll read does the same job through the data port without entering service. The vector base and the mode flags are exported for the neighbouring acknowledge and cascade logic.

Top module: `intc_regport`

## Requirements
- R1: A write to address 0 with data bit 4 set is an initialization word. It clears the mask, in-service and request registers, the priority offset, the read-select, poll, special-mask, auto-EOI, nested and rotate-on-auto-EOI flags. Data bit 0 records whether a mode word will follow.
- R2: The first address-1 write after an initialization word sets the vector base. Only data bits 7:3 are kept, and bits 2:0 of `base_o` read 0.
- R3: The second address-1 write after the initialization word is the cascade word. A third address-1 write is the mode word only when one was requested. The unit then returns to normal mode, where an address-1 write loads the mask.
- R4: In the mode word, bit 4 drives `sfnm_o` and bit 1 enables auto-EOI. With auto-EOI, service entry leaves no in-service bit set.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a poll. Bit 1 enables bit 0 to choose the address-0 readback, where 1 means in-service and 0 means request. Bit 6 enables bit 5 to drive `smm_o`.
- R6: An address-1 read returns the mask. An address-1 write in normal mode replaces it and leaves the in-service register unchanged.
- R7: When trigger bit i is 0, request bit i sets on a rising edge of `irq_in[i]` and stays set when the input falls. When trigger bit i is 1, request bit i follows the input level.
- R8: Writes with `trig_sel` high load the trigger register ANDed with `TRIG_WMASK` (default 0xF8). Reads with `trig_sel` high return that register.
- R9: Input i has rank (i − offset) mod 8, and rank 0 is the highest priority. `int_o` is high when an unmasked request exists whose best rank beats the best in-service rank, or when nothing is in service.
- R10: With `ack_i` high and `int_o` high, the winner's request bit is cleared (edge mode only) and its in-service bit is set. If auto-EOI and rotate-on-auto-EOI are both on, the in-service bit is left clear and the offset becomes winner+1.
- R11: Address-0 priority commands carry their code in data bits 7:5. Code 4 turns rotate-on-auto-EOI on and code 0 turns it off. Code 6 sets the offset to (bits 2:0 + 1) mod 8. Code 2 changes nothing.
- R12: Code 1 clears the best-ranked in-service bit. Code 5 does the same and sets the offset to that input + 1.
- R13: Code 3 clears in-service bit (data bits 2:0). Code 7 does the same and sets the offset to that input + 1.
- R14: After a poll is armed, the next read on either address returns 0x80 | winner, or 0x00 when there is no winner. It clears the winner's request and in-service bits and disarms the poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (poll side effect at clock edge) |
| trig_sel | input | 1 | Selects the trigger-mode register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| irq_in | input | 8 | Interrupt request inputs |
| ack_i | input | 1 | Service-entry strobe |
| int_o | output | 1 | Interrupt request to processor |
| base_o | output | 8 | Vector base |
| sfnm_o | output | 1 | Special nested mode flag |
| smm_o | output | 1 | Special mask flag |

## Verification
A wrong offset does not show right away. It surfaces at the next poll read or `int_o` decision in which two requests compete, so the tests always arm two inputs whose order depends on the offset. A stale in-service bit shows in two places: the same cycle it blocks `int_o`, and the next address-0 read once the in-service readback is selected. Errors in the setup sequence show one write late, as a mode word taken into the mask or a mask write swallowed as a setup word.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LINES = 8;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  typedef enum logic [2:0] {
    PC_ROT_OFF  = 3'd0,
    PC_EOI_ANY  = 3'd1,
    PC_NOP      = 3'd2,
    PC_EOI_ONE  = 3'd3,
    PC_ROT_ON   = 3'd4,
    PC_EOI_ROT  = 3'd5,
    PC_SET_OFFS = 3'd6,
    PC_ONE_ROT  = 3'd7
  } pcmd_e;
endpackage

// File: rtl/intc_rank.sv
module intc_rank #(
  parameter int N = 8,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    vec,
  input  logic [IDXW-1:0] offs,
  output logic            found,
  output logic [IDXW-1:0] rank,
  output logic [IDXW-1:0] idx
);
  logic [N-1:0] rot;

  always_comb begin
    rot = '0;
    for (int i = 0; i < N; i++) begin
      rot[i] = vec[IDXW'(i) + offs];
    end
  end

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) begin
        found = 1'b1;
        rank  = IDXW'(i);
      end
    end
  end

  assign idx = rank + offs;
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic want_mode,
  input  logic data_wr,
  output seq_e state,
  output logic running
);
  seq_e state_q, state_d;
  logic mode_q, mode_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    if (start) begin
      state_d = SEQ_BASE;
      mode_d  = want_mode;
    end else if (data_wr) begin
      unique case (state_q)
        SEQ_BASE: state_d = SEQ_CASC;
        SEQ_CASC: state_d = mode_q ? SEQ_MODE : SEQ_RUN;
        SEQ_MODE: state_d = SEQ_RUN;
        default:  state_d = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  assign state   = state_q;
  assign running = (state_q == SEQ_RUN);
endmodule

// File: rtl/intc_regport.sv
module intc_regport
  import intc_pkg::*;
#(
  parameter int N = LINES,
  parameter logic [N-1:0] TRIG_WMASK = 8'hF8,
  localparam int IDXW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         trig_sel,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] irq_in,
  input  logic         ack_i,
  output logic         int_o,
  output logic [N-1:0] base_o,
  output logic         sfnm_o,
  output logic         smm_o
);
  localparam logic [N-1:0] BASE_KEEP = {{(N-IDXW){1'b1}}, {IDXW{1'b0}}};

  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [N-1:0]    imr_q, imr_d, isr_q, isr_d, irr_q, irr_d;
  logic [N-1:0]    last_q, trig_q, trig_d, base_q, base_d, irr_clr, rise;
  logic [IDXW-1:0] offs_q, offs_d;
  logic            rot_q, rot_d, aeoi_q, aeoi_d, sfnm_q, sfnm_d;
  logic            smm_q, smm_d, rsel_q, rsel_d, poll_q, poll_d;
  logic            imr_en, base_en, trig_en;

  logic wr0, wr1, rd_any, icw1, ocw3, ocw2;
  assign wr0    = wr_en & ~trig_sel & ~addr;
  assign wr1    = wr_en & ~trig_sel & addr;
  assign rd_any = rd_en & ~trig_sel;
  assign icw1   = wr0 & wdata[4];
  assign ocw3   = wr0 & ~wdata[4] & wdata[3];
  assign ocw2   = wr0 & ~wdata[4] & ~wdata[3];

  pcmd_e           code;
  logic [IDXW-1:0] wsel;
  assign code = pcmd_e'(wdata[7:5]);
  assign wsel = wdata[IDXW-1:0];

  seq_e seq_st;
  logic running;
  intc_init_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (icw1),
    .want_mode(wdata[0]),
    .data_wr  (wr1),
    .state    (seq_st),
    .running  (running)
  );

  logic            req_found, isr_found, win;
  logic [IDXW-1:0] req_rank, req_idx, isr_rank, isr_idx;

  intc_rank #(.N(N)) u_req_rank (
    .vec  (irr_q & ~imr_q),
    .offs (offs_q),
    .found(req_found),
    .rank (req_rank),
    .idx  (req_idx)
  );

  intc_rank #(.N(N)) u_isr_rank (
    .vec  (isr_q),
    .offs (offs_q),
    .found(isr_found),
    .rank (isr_rank),
    .idx  (isr_idx)
  );

  assign win  = req_found & (~isr_found | (req_rank < isr_rank));
  assign rise = irq_in & ~last_q;

  always_comb begin
    imr_d  = imr_q;
    isr_d  = isr_q;
    offs_d = offs_q;
    rot_d  = rot_q;
    aeoi_d = aeoi_q;
    sfnm_d = sfnm_q;
    smm_d  = smm_q;
    rsel_d = rsel_q;
    poll_d = poll_q;
    base_d = base_q;
    irr_clr = '0;

    if (ack_i && win) begin
      if (!aeoi_q) isr_d[req_idx] = 1'b1;
      if (!trig_q[req_idx]) irr_clr[req_idx] = 1'b1;
      if (aeoi_q && rot_q) offs_d = req_idx + IDXW'(1);
    end

    if (rd_any && poll_q) begin
      poll_d = 1'b0;
      if (win) begin
        irr_clr[req_idx] = 1'b1;
        isr_d[req_idx]   = 1'b0;
      end
    end

    if (wr1) begin
      unique case (seq_st)
        SEQ_RUN:  imr_d = wdata;
        SEQ_BASE: base_d = wdata & BASE_KEEP;
        SEQ_MODE: begin
          sfnm_d = wdata[4];
          aeoi_d = wdata[1];
        end
        default: ;
      endcase
    end

    if (ocw3) begin
      poll_d = wdata[2];
      if (wdata[1]) rsel_d = wdata[0];
      if (wdata[6]) smm_d = wdata[5];
    end

    if (ocw2) begin
      unique case (code)
        PC_ROT_OFF, PC_ROT_ON: rot_d = code[2];
        PC_EOI_ANY, PC_EOI_ROT: begin
          if (isr_found) begin
            isr_d[isr_idx] = 1'b0;
            if (code[2]) offs_d = isr_idx + IDXW'(1);
          end
        end
        PC_EOI_ONE, PC_ONE_ROT: begin
          isr_d[wsel] = 1'b0;
          if (code[2]) offs_d = wsel + IDXW'(1);
        end
        PC_SET_OFFS: offs_d = wsel + IDXW'(1);
        default: ;
      endcase
    end

    irr_d = (((irr_q & ~irr_clr) | rise) & ~trig_q) | (irq_in & trig_q);

    if (icw1) begin
      imr_d  = '0;
      isr_d  = '0;
      irr_d  = '0;
      offs_d = '0;
      rot_d  = 1'b0;
      aeoi_d = 1'b0;
      sfnm_d = 1'b0;
      smm_d  = 1'b0;
      rsel_d = 1'b0;
      poll_d = 1'b0;
    end
  end

  assign imr_en  = wr1 | icw1;
  assign base_en = wr1 & (seq_st == SEQ_BASE);
  assign trig_en = wr_en & trig_sel;
  assign trig_d  = wdata & TRIG_WMASK;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      imr_q  <= '0;
      isr_q  <= '0;
      irr_q  <= '0;
      last_q <= '0;
      trig_q <= '0;
      base_q <= '0;
      offs_q <= '0;
      rot_q  <= 1'b0;
      aeoi_q <= 1'b0;
      sfnm_q <= 1'b0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      if (imr_en)  imr_q  <= imr_d;
      if (base_en) base_q <= base_d;
      if (trig_en) trig_q <= trig_d;
      isr_q  <= isr_d;
      irr_q  <= irr_d;
      last_q <= irq_in;
      offs_q <= offs_d;
      rot_q  <= rot_d;
      aeoi_q <= aeoi_d;
      sfnm_q <= sfnm_d;
      smm_q  <= smm_d;
      rsel_q <= rsel_d;
      poll_q <= poll_d;
    end
  end

  logic [N-1:0] poll_byte;
  assign poll_byte = win ? {1'b1, {(N-1-IDXW){1'b0}}, req_idx} : '0;

  always_comb begin
    if (trig_sel)    rdata = trig_q;
    else if (poll_q) rdata = poll_byte;
    else if (addr)   rdata = imr_q;
    else             rdata = rsel_q ? isr_q : irr_q;
  end

  assign int_o  = win;
  assign base_o = base_q;
  assign sfnm_o = sfnm_q;
  assign smm_o  = smm_q;
endmodule

// File: rtl/intc_regport_chk.sv
module intc_regport_chk #(
  parameter int N = 8,
  parameter logic [N-1:0] TRIG_WMASK = 8'hF8,
  localparam int IDXW = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         addr,
  input logic         wr_en,
  input logic         rd_en,
  input logic         trig_sel,
  input logic [N-1:0] wdata,
  input logic         ack_i,
  input logic [N-1:0] rdata,
  input logic         int_o,
  input logic [N-1:0] imr,
  input logic [N-1:0] isr,
  input logic [N-1:0] irr,
  input logic [N-1:0] trig,
  input logic         poll
);
  assert_init_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trig_sel && !addr && wdata[4]) |=> (imr == '0 && isr == '0));

  assert_mask_keeps_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trig_sel && addr && !ack_i && !rd_en) |=> $stable(isr));

  assert_trig_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig & ~TRIG_WMASK) == '0);

  assert_int_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~imr) != '0));

  assert_eoi_drops_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trig_sel && !addr && wdata[7:3] == 5'b00100 && isr != '0
     && !ack_i && !rd_en) |=> ($countones(isr) == $countones($past(isr)) - 1));

  assert_poll_format_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !trig_sel && poll) |-> (rdata[N-2:IDXW] == '0 && (rdata[N-1] == int_o)));
endmodule

bind intc_regport intc_regport_chk #(.N(N), .TRIG_WMASK(TRIG_WMASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .trig_sel(trig_sel),
  .wdata   (wdata),
  .ack_i   (ack_i),
  .rdata   (rdata),
  .int_o   (int_o),
  .imr     (imr_q),
  .isr     (isr_q),
  .irr     (irr_q),
  .trig    (trig_q),
  .poll    (poll_q)
);

// File: tb/sim_intc_regport.sv
`timescale 1ns/1ps
module sim_intc_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, trig_sel = 1'b0, ack_i = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, base_o;
  logic       int_o, sfnm_o, smm_o;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  intc_regport u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .trig_sel(trig_sel), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .ack_i(ack_i), .int_o(int_o), .base_o(base_o), .sfnm_o(sfnm_o), .smm_o(smm_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d, logic ts = 1'b0);
    @(negedge clk); addr = a; wdata = d; trig_sel = ts; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; trig_sel = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v, input logic ts = 1'b0);
    @(negedge clk); addr = a; trig_sel = ts; rd_en = 1'b1;
    #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0; trig_sel = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ack_i = 1'b1;
    @(posedge clk); #1 ack_i = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic setup(logic need4, logic [7:0] mode);
    wr(0, 8'h10 | {7'd0, need4});
    wr(1, 8'h08);
    wr(1, 8'h00);
    if (need4) wr(1, mode);
  endtask

  task automatic look_int(string tag, logic e);
    @(negedge clk); #1 chk(tag, {7'd0, int_o}, {7'd0, e});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1, v); chk("R1 reset mask", v, 8'h00);
    rd(0, v); chk("R1 reset request", v, 8'h00);
    look_int("R9 reset int", 1'b0);
    chk("R2 reset base", base_o, 8'h00);
  endtask

  task automatic t_sequence();
    logic [7:0] v;
    wr(0, 8'h10); wr(1, 8'h45);
    chk("R2 base top bits", base_o, 8'h40);
    wr(1, 8'h00); wr(1, 8'h5A);
    rd(1, v); chk("R3 mask after short sequence", v, 8'h5A);
    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h12);
    rd(1, v); chk("R3 mode word not taken as mask", v, 8'h00);
    chk("R4 nested flag", {7'd0, sfnm_o}, 8'h01);
    wr(1, 8'h3C);
    rd(1, v); chk("R6 mask write/read", v, 8'h3C);
  endtask

  task automatic t_trigger();
    logic [7:0] v;
    setup(0, 0);
    wr(0, 8'hFF, 1'b1);
    rd(0, v, 1'b1); chk("R8 writable bits", v, 8'hF8);
    wr(0, 8'h08, 1'b1);
    @(negedge clk); irq_in = 8'h0C;
    rd(0, v); chk("R7 level and edge set", v, 8'h0C);
    @(negedge clk); irq_in = 8'h00;
    rd(0, v); chk("R7 level follows, edge holds", v, 8'h04);
    wr(0, 8'h00, 1'b1);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    setup(0, 0);
    pulse(8'h24);
    look_int("R9 int with requests", 1'b1);
    ack();
    look_int("R9 lower request blocked", 1'b0);
    wr(0, 8'h0B); rd(0, v); chk("R10 service entry", v, 8'h04);
    wr(0, 8'h0A); rd(0, v); chk("R10 request cleared", v, 8'h20);
    wr(0, 8'h20);
    look_int("R12 eoi frees level", 1'b1);
    ack();
    wr(0, 8'hA0);
    wr(0, 8'h0B); rd(0, v); chk("R12 rotate eoi clears", v, 8'h00);
    pulse(8'h81);
    wr(0, 8'h0C); rd(0, v); chk("R14 poll after rotation R12", v, 8'h87);
    rd(1, v); chk("R14 poll flag one read", v, 8'h00);
    wr(0, 8'h0C); rd(1, v); chk("R14 poll second", v, 8'h80);
    wr(0, 8'h0C); rd(0, v); chk("R14 poll none", v, 8'h00);
    wr(0, 8'h0A); rd(0, v); chk("R14 poll cleared requests", v, 8'h00);
  endtask

  task automatic t_specific();
    logic [7:0] v;
    setup(0, 0);
    pulse(8'h0A);
    ack();
    look_int("R9 blocked by service", 1'b0);
    wr(0, 8'hC2);
    look_int("R11 set offset changes order", 1'b1);
    ack();
    wr(0, 8'h40);
    wr(0, 8'h0B); rd(0, v); chk("R11 code 2 no change", v, 8'h0A);
    wr(0, 8'h61); rd(0, v); chk("R13 specific eoi", v, 8'h08);
    wr(0, 8'hE3); rd(0, v); chk("R13 specific rotate clears", v, 8'h00);
    pulse(8'h14);
    wr(0, 8'h0C); rd(0, v); chk("R13 offset after rotate", v, 8'h84);
  endtask

  task automatic t_auto_eoi();
    logic [7:0] v;
    setup(1, 8'h02);
    wr(0, 8'h80);
    pulse(8'h44);
    ack();
    wr(0, 8'h0B); rd(0, v); chk("R4 auto eoi leaves none", v, 8'h00);
    pulse(8'h02);
    wr(0, 8'h0C); rd(0, v); chk("R10 rotate on auto eoi", v, 8'h86);
    wr(0, 8'h00);
    ack();
    pulse(8'h0C);
    wr(0, 8'h0C); rd(0, v); chk("R11 code 0 stops rotation", v, 8'h83);
  endtask

  task automatic t_mode_cmd();
    logic [7:0] v;
    setup(0, 0);
    wr(0, 8'h68); chk("R5 special mask set", {7'd0, smm_o}, 8'h01);
    wr(0, 8'h28); chk("R5 special mask gated", {7'd0, smm_o}, 8'h01);
    wr(0, 8'h48); chk("R5 special mask clear", {7'd0, smm_o}, 8'h00);
    pulse(8'h10);
    wr(0, 8'h0B); rd(0, v); chk("R5 select service", v, 8'h00);
    wr(0, 8'h09); rd(0, v); chk("R5 select gated", v, 8'h00);
    wr(0, 8'h0A); rd(0, v); chk("R5 select request", v, 8'h10);
  endtask

  task automatic t_reinit();
    logic [7:0] v;
    ack();
    wr(1, 8'h33);
    wr(0, 8'h0B); rd(0, v); chk("R6 mask write keeps service", v, 8'h10);
    wr(0, 8'h10);
    rd(1, v); chk("R1 mask cleared", v, 8'h00);
    rd(0, v); chk("R1 request cleared", v, 8'h00);
    wr(0, 8'h0B); rd(0, v); chk("R1 service cleared", v, 8'h00);
    wr(1, 8'h00); wr(1, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_sequence();
    t_trigger();
    t_priority();
    t_specific();
    t_auto_eoi();
    t_mode_cmd();
    t_reinit();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule